// File: doc/BRIEF.md
# Two-Port Latched-Address Register File

The block is a bank of sixteen 8-bit general-purpose registers that sits on a single 8-bit internal bus. The block has two 4-bit address latches, one for writes and one for reads. Each latch takes its value from the low nibble of the bus when its own load strobe is high. After that, a write strobe stores the bus byte into the register that the write latch selects. A read enable places the register that the read latch selects on the bus driver.

The block can move a 16-bit value over the 8-bit bus in two consecutive cycles. To do this, the pair-step control is raised together with the write strobe or the read enable. The latch that serves that transfer then advances by one at the clock edge, so the next cycle reaches the partner register. For example, a read of r14 is followed by r15, and a write of r8 is followed by r9. The step wraps from 15 back to 0.

The bus driver is split into a data byte and an output-enable, so a pad-level tri-state buffer can be placed outside the block.

Top module: `gpr_pair_file`

## Requirements
- R1: Reset clears the write-address latch and the read-address latch to 0, and `bus_oe` is low whenever `rd_en` is low. Register contents are not reset.
- R2: When `wa_ld` is high at a rising edge, the write latch takes `bus_in[3:0]`. Bits 7:4 are ignored.
- R3: When `ra_ld` is high at a rising edge, the read latch takes `bus_in[3:0]`. Bits 7:4 are ignored.
- R4: When `wr_stb` is high at a rising edge, `bus_in` is stored into the register that the write latch selects. When `wr_stb` is low, no register changes.
- R5: While `rd_en` is high, `bus_oe` is high and `bus_out` shows the register that the read latch selects, in the same cycle with no register stage.
- R6: When `pair_inc` and `wr_stb` are both high at an edge, the write latch advances by one after the write, wrapping from 15 to 0.
- R7: When `pair_inc` and `rd_en` are both high at an edge, the read latch advances by one, wrapping from 15 to 0.
- R8: When `pair_inc` is high without the matching strobe or enable, the corresponding latch keeps its value.
- R9: A read and a write of the same register in one cycle return the old contents. The new value is visible from the next cycle.
- R10: A latch load and a pair step in the same cycle resolve to the loaded value. A write in that cycle uses the address held before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the address latches |
| bus_in | input | 8 | Internal bus value (data, or an address in bits 3:0) |
| wa_ld | input | 1 | Load the write-address latch |
| ra_ld | input | 1 | Load the read-address latch |
| wr_stb | input | 1 | Write the bus byte into the selected register |
| rd_en | input | 1 | Drive the selected register toward the bus |
| pair_inc | input | 1 | Step the latch in use to the partner register |
| bus_out | output | 8 | Selected register value, zero when not reading |
| bus_oe | output | 1 | Enable for the external bus buffer |

## Verification
Latch loads, pair steps and register writes take effect at the rising edge where their strobe is high. Their results are therefore checked only in a later cycle, through a read. A read is combinational, so `bus_out` and `bus_oe` are due in the same cycle as `rd_en`. The bench sets every input just after a falling edge and samples the outputs two nanoseconds later, which is before the next rising edge. For this reason, the same-cycle read-during-write case can only observe the old contents.

// File: rtl/gpr_pair_file.sv
module gpr_pair_file #(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_in,
  input  logic          wa_ld,
  input  logic          ra_ld,
  input  logic          wr_stb,
  input  logic          rd_en,
  input  logic          pair_inc,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe
);
  localparam int AW = $clog2(NREG);

  logic [DW-1:0] mem [NREG];
  logic [AW-1:0] waddr, raddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 waddr <= '0;
    else if (wa_ld)             waddr <= bus_in[AW-1:0];
    else if (wr_stb && pair_inc) waddr <= waddr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 raddr <= '0;
    else if (ra_ld)             raddr <= bus_in[AW-1:0];
    else if (rd_en && pair_inc) raddr <= raddr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_stb) mem[waddr] <= bus_in;
  end

  assign bus_oe  = rd_en;
  assign bus_out = rd_en ? mem[raddr] : '0;

  AST_WLATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wa_ld |=> waddr == $past(bus_in[AW-1:0])); // R2
  AST_RLATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ra_ld |=> raddr == $past(bus_in[AW-1:0])); // R3
  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> mem[$past(waddr)] == $past(bus_in)); // R4
  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && pair_inc && !wa_ld) |=> waddr == $past(waddr) + AW'(1)); // R6
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && pair_inc && !ra_ld) |=> raddr == $past(raddr) + AW'(1)); // R7
  AST_WLATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wa_ld && !(wr_stb && pair_inc)) |=> $stable(waddr)); // R8
  AST_RLATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ra_ld && !(rd_en && pair_inc)) |=> $stable(raddr)); // R8
endmodule

// File: tb/gpr_pair_file_bench.sv
module gpr_pair_file_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_in = '0;
  logic       wa_ld = 0, ra_ld = 0, wr_stb = 0, rd_en = 0, pair_inc = 0;
  logic [7:0] bus_out;
  logic       bus_oe;
  int         checks = 0, fails = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  gpr_pair_file u_gpr_pair_file (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .wa_ld(wa_ld), .ra_ld(ra_ld),
    .wr_stb(wr_stb), .rd_en(rd_en), .pair_inc(pair_inc),
    .bus_out(bus_out), .bus_oe(bus_oe));

  // op: 0 load write latch, 1 load read latch, 2 write, 3 read+check
  localparam int NV = 22;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 8'h08, 1'b0, 8'h00},
    {2'd2, 8'hA1, 1'b1, 8'h00},  // R6 r8
    {2'd2, 8'hB2, 1'b1, 8'h00},  // R6 r9
    {2'd1, 8'h08, 1'b0, 8'h00},
    {2'd3, 8'h00, 1'b1, 8'hA1},  // R7 r8
    {2'd3, 8'h00, 1'b1, 8'hB2},  // R7 r9
    {2'd0, 8'h0E, 1'b0, 8'h00},
    {2'd2, 8'h3C, 1'b1, 8'h00},  // r14
    {2'd2, 8'h4D, 1'b1, 8'h00},  // r15
    {2'd2, 8'h5E, 1'b0, 8'h00},  // R6 wrap to r0
    {2'd1, 8'h0E, 1'b0, 8'h00},
    {2'd3, 8'h00, 1'b1, 8'h3C},
    {2'd3, 8'h00, 1'b1, 8'h4D},
    {2'd3, 8'h00, 1'b0, 8'h5E},  // R7 wrap to r0
    {2'd3, 8'h00, 1'b0, 8'h5E},  // no step without pair_inc
    {2'd0, 8'hF3, 1'b0, 8'h00},  // R2 upper nibble ignored
    {2'd2, 8'h77, 1'b0, 8'h00},
    {2'd1, 8'hA3, 1'b0, 8'h00},  // R3 upper nibble ignored
    {2'd3, 8'h00, 1'b0, 8'h77},
    {2'd0, 8'h0B, 1'b0, 8'h00},
    {2'd2, 8'hC4, 1'b0, 8'h00},
    {2'd1, 8'h0B, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wl, input logic rl, input logic wr, input logic rd,
                       input logic inc, input logic [7:0] d);
    @(negedge clk);
    wa_ld = wl; ra_ld = rl; wr_stb = wr; rd_en = rd; pair_inc = inc; bus_in = d;
    #2;
  endtask

  task automatic rd_chk(input string req, input logic inc, input logic [7:0] exp);
    drive(0, 0, 0, 1, inc, 8'h00);
    chk(req, {7'd0, bus_oe}, 8'h01);
    chk(req, bus_out, exp);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 oe idle", {7'd0, bus_oe}, 8'h00);
    chk("R1 out idle", bus_out, 8'h00);
    drive(0, 0, 1, 0, 0, 8'h99);        // write lands on r0
    rd_chk("R1 latches zero", 0, 8'h99);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][18:17];
      case (op)
        2'd0: drive(1, 0, 0, 0, VEC[i][8], VEC[i][16:9]);
        2'd1: drive(0, 1, 0, 0, VEC[i][8], VEC[i][16:9]);
        2'd2: drive(0, 0, 1, 0, VEC[i][8], VEC[i][16:9]);
        default: rd_chk("R4 R5 table", VEC[i][8], VEC[i][7:0]);
      endcase
    end
    // Table leaves r11 = C4 with both latches at 11.
    rd_chk("R5 r11", 0, 8'hC4);

    drive(0, 0, 0, 0, 0, 8'hEE);        // R4: no write without wr_stb
    drive(0, 0, 0, 0, 0, 8'h11);
    rd_chk("R4 no write", 0, 8'hC4);
    drive(0, 0, 0, 0, 1, 8'h00);        // R8: pair_inc alone
    drive(0, 0, 0, 0, 1, 8'h00);
    rd_chk("R8 read latch held", 0, 8'hC4);
    drive(0, 0, 1, 0, 0, 8'h5A);        // write latch still 11
    rd_chk("R8 write latch held", 0, 8'h5A);

    drive(0, 0, 1, 1, 0, 8'h66);        // R9 read during write
    chk("R9 oe", {7'd0, bus_oe}, 8'h01);
    chk("R9 old value", bus_out, 8'h5A);
    rd_chk("R9 new value", 0, 8'h66);

    drive(1, 0, 0, 0, 0, 8'h02);        // R10
    drive(1, 0, 1, 0, 1, 8'h06);        // write r2 with 06, latch -> 6
    drive(0, 0, 1, 0, 0, 8'h44);        // r6
    drive(0, 1, 0, 0, 0, 8'h02);
    rd_chk("R10 old address written", 0, 8'h06);
    drive(0, 1, 0, 1, 1, 8'h06);        // load beats step on read side
    chk("R10 read in load cycle", bus_out, 8'h06);
    rd_chk("R10 load wins read", 0, 8'h44);

    drive(0, 0, 0, 0, 0, 8'h00);
    chk("R1 oe low", {7'd0, bus_oe}, 8'h00);
    chk("R5 out quiet", bus_out, 8'h00);
    summary();
  end
endmodule